// File: doc/BRIEF.md
# Address Break Exception Sequencer

This block watches the instruction-fetch address bus. It compares every fetch against a programmable break address. When a fetch hits that address and breaking is enabled, the block pulses a break request. It then lets the pipeline finish the fetches that are already committed, and after that it plays out the exception-entry bus cycles as a stream of commands. Each command carries a cycle-type code, an address and, for writes, the data word.

Where the break takes effect depends on the memory region that holds the break address.

- **On-chip, single-state memory:** two more fetches follow the breaking one. The saved return address is the break address plus four. This is true whether the instruction at the break address is a 2-byte instruction or a 4-byte instruction with an immediate. In the first case the next 2-byte instruction also completes. In the second case nothing after it runs.
- **External, two-state 16-bit memory:** only one more fetch follows. The instruction at the break address does not execute, so the saved return address is the break address itself.

Because the return address is the same for both instruction lengths, the block needs no length input.

After the trailing fetches, the entry sequence runs in this order:

1. An internal cycle.
2. A write of the return address to SP-2.
3. A write of the status word to SP-4.
4. A read of the handler vector at address 0x0036.
5. A second internal cycle.
6. A fetch from the handler address that the vector read returned.

On the final cycle the block reports the stack pointer lowered by four.

Top module: `addr_break_seq`

## Requirements
- R1: A fetch with `fetch_valid` high, `fetch_addr` equal to `brk_addr` and `brk_en` high, accepted while the block is idle, makes `brk_req` high for exactly the next cycle. With `brk_en` low, no break occurs.
- R2: For an on-chip break address (`ext_region` low), the first two command cycles are fetches (type 0) at break address +2 and +4. The return address is break address +4.
- R3: For an external break address (`ext_region` high), exactly one fetch at break address +2 precedes the entry sequence. The return address equals the break address.
- R4: After the trailing fetches, the commands follow this fixed order: internal (type 1), stack write (type 2) to SP-2 carrying the return address, stack write to SP-4 carrying the status word, vector read (type 3) at 0x0036, internal, then one fetch.
- R5: The final fetch of the sequence uses the word presented on `vec_data` during the vector-read cycle as its address.
- R6: In the final fetch cycle `sp_upd` is high and `sp_new` equals the captured SP minus 4. At all other times `sp_upd` is low.
- R7: While a sequence is in progress, matching fetches are ignored: `brk_req` stays low and the command stream is unchanged.
- R8: A match on the address bus with `fetch_valid` low causes no break.
- R9: After reset, `brk_req`, `cmd_valid` and `sp_upd` are low. `ret_addr` holds its value after a sequence until the next break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_en | input | 1 | Enables break detection |
| brk_addr | input | AW | Programmed break address |
| fetch_valid | input | 1 | Instruction-fetch strobe |
| fetch_addr | input | AW | Address of the current fetch |
| ext_region | input | 1 | Break fetch is from external two-state memory |
| sp_in | input | AW | Stack pointer, captured at the break |
| status_in | input | AW | Status word, captured at the break |
| vec_data | input | AW | Data returned by the vector read |
| brk_req | output | 1 | One-cycle break request |
| ret_addr | output | AW | Computed return address |
| cmd_valid | output | 1 | Command strobe |
| cmd_type | output | 2 | 0 fetch, 1 internal, 2 stack write, 3 vector read |
| cmd_addr | output | AW | Command address |
| cmd_wdata | output | AW | Write data for stack writes |
| sp_upd | output | 1 | Stack pointer update strobe |
| sp_new | output | AW | Updated stack pointer |

## Verification
The assertions assume three things about the inputs:

- `sp_in` and `status_in` are meaningful in the cycle of the breaking fetch.
- `vec_data` is valid during the vector-read cycle.
- `brk_addr` does not change while a sequence runs.

The stimulus holds all of these values constant for the whole of each scenario and changes them only between scenarios, while the block is idle. To exercise the ignore rule, it keeps a matching fetch on the bus for the whole sequence. It lowers the strobe before the idle cycle, so the next break is always intended.

// File: rtl/addr_break_seq.sv
module addr_break_seq #(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_ADDR = 16'h0036
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_en,
  input  logic [AW-1:0] brk_addr,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          ext_region,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] status_in,
  input  logic [AW-1:0] vec_data,
  output logic          brk_req,
  output logic [AW-1:0] ret_addr,
  output logic          cmd_valid,
  output logic [1:0]    cmd_type,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_wdata,
  output logic          sp_upd,
  output logic [AW-1:0] sp_new
);
  localparam logic [1:0] T_FETCH = 2'd0;
  localparam logic [1:0] T_INT   = 2'd1;
  localparam logic [1:0] T_WR    = 2'd2;
  localparam logic [1:0] T_VEC   = 2'd3;
  localparam logic [AW-1:0] TWO  = AW'(2);
  localparam logic [AW-1:0] FOUR = AW'(4);

  typedef enum logic [3:0] {
    S_IDLE, S_PF1, S_PF2, S_INT1, S_SW1, S_SW2, S_VEC, S_INT2, S_HF
  } state_t;

  state_t st_q, st_d;
  logic [AW-1:0] a_q, sp_q, stat_q, hnd_q;
  logic          ext_q;

  wire hit = brk_en && fetch_valid && (fetch_addr == brk_addr) && (st_q == S_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (hit) st_d = S_PF1;
      S_PF1:  st_d = ext_q ? S_INT1 : S_PF2;
      S_PF2:  st_d = S_INT1;
      S_INT1: st_d = S_SW1;
      S_SW1:  st_d = S_SW2;
      S_SW2:  st_d = S_VEC;
      S_VEC:  st_d = S_INT2;
      S_INT2: st_d = S_HF;
      S_HF:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      a_q      <= '0;
      sp_q     <= '0;
      stat_q   <= '0;
      hnd_q    <= '0;
      ext_q    <= 1'b0;
      ret_addr <= '0;
    end else begin
      st_q <= st_d;
      if (hit) begin
        a_q      <= fetch_addr;
        sp_q     <= sp_in;
        stat_q   <= status_in;
        ext_q    <= ext_region;
        ret_addr <= ext_region ? fetch_addr : fetch_addr + FOUR;
      end
      if (st_q == S_VEC) hnd_q <= vec_data;
    end
  end

  assign brk_req   = (st_q == S_PF1);
  assign cmd_valid = (st_q != S_IDLE);
  assign sp_upd    = (st_q == S_HF);
  assign sp_new    = sp_q - FOUR;

  always_comb begin
    cmd_type  = T_INT;
    cmd_addr  = '0;
    cmd_wdata = '0;
    unique case (st_q)
      S_PF1:  begin cmd_type = T_FETCH; cmd_addr = a_q + TWO; end
      S_PF2:  begin cmd_type = T_FETCH; cmd_addr = a_q + FOUR; end
      S_SW1:  begin cmd_type = T_WR; cmd_addr = sp_q - TWO;  cmd_wdata = ret_addr; end
      S_SW2:  begin cmd_type = T_WR; cmd_addr = sp_q - FOUR; cmd_wdata = stat_q; end
      S_VEC:  begin cmd_type = T_VEC; cmd_addr = VEC_ADDR; end
      S_HF:   begin cmd_type = T_FETCH; cmd_addr = hnd_q; end
      default: ;
    endcase
  end

  // R1: a qualified match yields a request in the following cycle
  p_req_after_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_en && fetch_valid && fetch_addr == brk_addr && !cmd_valid) |=> brk_req);

  // R7: no request while a sequence is already running
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !brk_req);

  // R4: the status write follows the return-address write
  p_write_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == T_WR && cmd_wdata == ret_addr && cmd_addr == sp_new + TWO)
      |=> (cmd_type == T_WR && cmd_addr == sp_new));

  // R4: the vector read comes straight after the second stack write
  p_vec_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == T_WR && cmd_addr == sp_new) |=> (cmd_type == T_VEC && cmd_addr == VEC_ADDR));

  // R5: the handler fetch uses the vector data
  p_handler_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_type == T_VEC) |=> ##1 (cmd_type == T_FETCH && cmd_addr == $past(vec_data, 2)));

  // R6: the stack-pointer update ends the sequence
  p_sp_upd_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sp_upd |=> !cmd_valid);

  // R9: the return address is stable while a sequence runs
  p_ret_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !brk_req) |-> $stable(ret_addr));
endmodule

// File: tb/addr_break_seq_bench.sv
module addr_break_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        brk_en = 1'b0;
  logic [15:0] brk_addr = '0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        ext_region = 1'b0;
  logic [15:0] sp_in = '0;
  logic [15:0] status_in = '0;
  logic [15:0] vec_data = '0;
  logic        brk_req;
  logic [15:0] ret_addr;
  logic        cmd_valid;
  logic [1:0]  cmd_type;
  logic [15:0] cmd_addr;
  logic [15:0] cmd_wdata;
  logic        sp_upd;
  logic [15:0] sp_new;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  addr_break_seq u_addr_break_seq (
    .clk(clk), .rst_n(rst_n), .brk_en(brk_en), .brk_addr(brk_addr),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .ext_region(ext_region),
    .sp_in(sp_in), .status_in(status_in), .vec_data(vec_data),
    .brk_req(brk_req), .ret_addr(ret_addr), .cmd_valid(cmd_valid),
    .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .sp_upd(sp_upd), .sp_new(sp_new)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_break(input string req, input logic [15:0] a, input logic ext,
                           input logic [15:0] sp, input logic [15:0] stv,
                           input logic [15:0] vec, input logic hammer);
    logic [1:0]  et [9];
    logic [15:0] ea [9];
    logic [15:0] ew [9];
    logic [15:0] ret;
    int n;
    int k;
    ret = ext ? a : a + 16'd4;
    n = 0;
    et[n] = 2'd0; ea[n] = a + 16'd2; ew[n] = 16'h0; n++;
    if (!ext) begin et[n] = 2'd0; ea[n] = a + 16'd4; ew[n] = 16'h0; n++; end
    et[n] = 2'd1; ea[n] = 16'h0;       ew[n] = 16'h0; n++;
    et[n] = 2'd2; ea[n] = sp - 16'd2;  ew[n] = ret;   n++;
    et[n] = 2'd2; ea[n] = sp - 16'd4;  ew[n] = stv;   n++;
    et[n] = 2'd3; ea[n] = 16'h0036;    ew[n] = 16'h0; n++;
    et[n] = 2'd1; ea[n] = 16'h0;       ew[n] = 16'h0; n++;
    et[n] = 2'd0; ea[n] = vec;         ew[n] = 16'h0; n++;
    @(negedge clk);
    brk_en = 1'b1; brk_addr = a; fetch_addr = a; fetch_valid = 1'b1;
    ext_region = ext; sp_in = sp; status_in = stv; vec_data = vec;
    @(negedge clk);
    if (!hammer) fetch_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) fetch_valid = 1'b0;
      chk(i == 0 ? "R1" : "R7", "brk_req", {15'b0, brk_req}, {15'b0, i == 0});
      chk(req, "cmd_valid", {15'b0, cmd_valid}, 16'h1);
      chk(i < 2 ? req : "R4", "cmd_type", {14'b0, cmd_type}, {14'b0, et[i]});
      if (!(et[i] == 2'd1)) chk(i == n - 1 ? "R5" : (i < 2 ? req : "R4"), "cmd_addr", cmd_addr, ea[i]);
      if (et[i] == 2'd2) chk("R4", "cmd_wdata", cmd_wdata, ew[i]);
      chk("R6", "sp_upd", {15'b0, sp_upd}, {15'b0, i == n - 1});
      if (i == n - 1) chk("R6", "sp_new", sp_new, sp - 16'd4);
      chk(req, "ret_addr", ret_addr, ret);
      @(negedge clk);
    end
    k = 0;
    chk("R9", "cmd_valid idle", {15'b0, cmd_valid}, 16'h0);
    chk("R9", "ret_addr held", ret_addr, ret);
    chk("R9", "brk_req idle", {15'b0, brk_req}, 16'h0);
  endtask

  task automatic t_reset;
    chk("R9", "reset brk_req", {15'b0, brk_req}, 16'h0);
    chk("R9", "reset cmd_valid", {15'b0, cmd_valid}, 16'h0);
    chk("R9", "reset sp_upd", {15'b0, sp_upd}, 16'h0);
  endtask

  task automatic t_quiet(input string req, input logic en, input logic fv);
    @(negedge clk);
    brk_en = en; brk_addr = 16'h0400; fetch_addr = 16'h0400; fetch_valid = fv;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(req, "no brk_req", {15'b0, brk_req}, 16'h0);
    chk(req, "no cmd_valid", {15'b0, cmd_valid}, 16'h0);
    @(negedge clk);
    chk(req, "still idle", {15'b0, cmd_valid}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_break("R2", 16'h0312, 1'b0, 16'hFF00, 16'h8A05, 16'h1234, 1'b0);
    run_break("R3", 16'h0312, 1'b1, 16'hFE80, 16'h0042, 16'h2000, 1'b0);
    run_break("R2", 16'hFFFE, 1'b0, 16'h0004, 16'hFFFF, 16'h0000, 1'b0);
    run_break("R3", 16'h7000, 1'b1, 16'h0002, 16'h1111, 16'hABCD, 1'b0);
    run_break("R7", 16'h0500, 1'b0, 16'h8000, 16'h5555, 16'h3000, 1'b1);
    run_break("R7", 16'h0600, 1'b1, 16'h9000, 16'hAAAA, 16'h3100, 1'b1);
    t_quiet("R1", 1'b0, 1'b1);
    t_quiet("R8", 1'b1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule